// File: doc/BRIEF.md
# Multi-Level Resistive Cell Access Sequencer

This block runs single accesses to a small bank of resistive memory cells that each hold several bits as one of 2^BITS resistance levels. Every access opens with a sensing window. During this window the array develops a bitline voltage and a bank of 2^BITS−1 comparators reports it as a thermometer pattern against fixed references. The block turns that pattern into a level and then into Gray-coded data. A read may then need a restoring window, because sensing disturbs the cell. A write always follows its sensing window with a programming window.

Restoring runs under one of two policies, selected by an input. In the first, every read is restored. In the second, a saturating counter per cell records the reads since that cell was last written or restored, and a restore runs only once the count passes a programmable threshold. Next to each counter the block keeps the level it last saw in or wrote to the cell. That level drives the array during a restore. The host side is a plain valid/ready request port with a one-cycle response pulse. The array side has the three phase enables, a drive polarity and a drive level.

Top module: `mlc_access_seq`

## Requirements
- R1: `req_ready` is high while idle. It goes low in the cycle after a request is accepted and stays low until the last phase of that access has finished. A request presented while the block is busy starts no access.
- R2: Every access starts with `sense_en` high for `sense_cycles` cycles, or for one cycle when `sense_cycles` is 0. A write then holds `prog_en` high for `prog_cycles` cycles, or for one cycle when that input is 0. A write gives no response pulse.
- R3: `cmp_above[k]` is 1 when the bitline lies above reference k+1. In the cycle after the last sensing cycle of a read, `rsp_valid` is high for one cycle. The level is the number of set comparator bits, and `rsp_data` gives levels 0,1,2,3 as 00,01,11,10 (level XOR level>>1).
- R4: A comparator pattern that is not a thermometer code (a higher bit set while a lower bit is clear) sets `rsp_err` with the response. The data still comes from the number of set bits. A valid pattern leaves `rsp_err` low.
- R5: With `refresh_by_count`=0, every read is followed by `restore_en` high for exactly as many cycles as its sensing window lasted. `drive_neg` stays high throughout the restore, and `drive_level` equals the sensed level.
- R6: With `refresh_by_count`=1, each cell counts its reads, and the count includes the current read. A restore follows only when the count exceeds `read_threshold`, and that restore clears the count.
- R7: A write clears the read count of its own cell and leaves the counts of all other cells unchanged.
- R8: The read count saturates at 2^CNT_W−1 and never wraps.
- R9: During programming, `drive_level` is the level of `req_wdata` (00→0, 01→1, 11→2, 10→3). `drive_neg` is high exactly when that level is below the level sensed at the start of the write.
- R10: At most one of `sense_en`, `restore_en` and `prog_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (3) | Cell index |
| req_wdata | input | BITS (2) | Gray-coded write data |
| sense_cycles | input | CYC_W (8) | Sensing window length in cycles |
| prog_cycles | input | CYC_W (8) | Programming window length in cycles |
| refresh_by_count | input | 1 | 0 = restore every read, 1 = counter policy |
| read_threshold | input | CNT_W (6) | Read count that must be exceeded before a restore |
| cmp_above | input | 2^BITS−1 (3) | Comparator outputs, bit k = above reference k+1 |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | BITS (2) | Gray-coded read data |
| rsp_err | output | 1 | Comparator pattern was not a thermometer code |
| cell_addr | output | AW (3) | Cell selected by the access in flight |
| sense_en | output | 1 | Sensing phase enable |
| restore_en | output | 1 | Restoring phase enable |
| prog_en | output | 1 | Programming phase enable |
| drive_neg | output | 1 | Reversed drive polarity during restore or program |
| drive_level | output | BITS (2) | Level driven during restore or program |

## Verification
The saturation of a read counter is the hardest state to reach, and it shows at the ports only indirectly. The stimulus reads one cell 65 times under a threshold of 63, which can never be exceeded. It then lowers the threshold to 62 and reads once more. A saturated counter triggers a restore on that read, while a wrapped counter would hold a small value and trigger none. The per-cell clearing and independence are reached by interleaving reads and writes to two cells under a low threshold.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SENSE   = 2'd1,
    PH_RESTORE = 2'd2,
    PH_PROGRAM = 2'd3
  } phase_e;
endpackage

// File: rtl/mlc_level_decode.sv
module mlc_level_decode #(
  parameter int BITS = 2,
  localparam int NCMP = (1 << BITS) - 1
) (
  input  logic [NCMP-1:0] cmp,
  output logic [BITS-1:0] level,
  output logic [BITS-1:0] gray,
  output logic            bad_code
);
  function automatic logic [BITS-1:0] count_set(input logic [NCMP-1:0] c);
    int n;
    n = 0;
    for (int i = 0; i < NCMP; i++) n += int'(c[i]);
    return BITS'(n);
  endfunction

  function automatic logic is_thermo(input logic [NCMP-1:0] c);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < NCMP; i++)
      if (c[i] && !c[i-1]) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    level    = count_set(cmp);
    gray     = level ^ (level >> 1);
    bad_code = !is_thermo(cmp);
  end
endmodule

// File: rtl/mlc_read_tracker.sv
module mlc_read_tracker #(
  parameter int BITS  = 2,
  parameter int CELLS = 8,
  parameter int CNT_W = 6,
  localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             rd_upd,
  input  logic             wr_upd,
  input  logic             clr_cnt,
  input  logic [BITS-1:0]  new_level,
  output logic [CNT_W-1:0] cnt_next,
  output logic [BITS-1:0]  cur_level
);
  logic [CNT_W-1:0] cnt_q [CELLS];
  logic [BITS-1:0]  lvl_q [CELLS];

  assign cnt_next  = (cnt_q[addr] == CMAX) ? CMAX : cnt_q[addr] + 1'b1;
  assign cur_level = lvl_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        cnt_q[i] <= '0;
        lvl_q[i] <= '0;
      end
    end else if (wr_upd) begin
      cnt_q[addr] <= '0;
      lvl_q[addr] <= new_level;
    end else if (rd_upd) begin
      cnt_q[addr] <= clr_cnt ? '0 : cnt_next;
      lvl_q[addr] <= new_level;
    end
  end

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd |=> cnt_q[$past(addr)] == '0);

  p_cnt_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upd && !wr_upd && !clr_cnt && cnt_q[addr] == CMAX) |=> cnt_q[$past(addr)] == CMAX);
endmodule

// File: rtl/mlc_phase_seq.sv
module mlc_phase_seq
  import mlc_pkg::*;
#(
  parameter int BITS  = 2,
  parameter int CELLS = 8,
  parameter int CNT_W = 6,
  parameter int CYC_W = 8,
  localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [BITS-1:0]  req_wdata,
  input  logic [CYC_W-1:0] sense_cycles,
  input  logic [CYC_W-1:0] prog_cycles,
  input  logic             refresh_by_count,
  input  logic [CNT_W-1:0] read_threshold,
  input  logic [BITS-1:0]  sensed_level,
  input  logic [BITS-1:0]  sensed_gray,
  input  logic             sensed_bad,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [BITS-1:0]  tracked_level,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [BITS-1:0]  rsp_data,
  output logic             rsp_err,
  output logic [AW-1:0]    addr_q,
  output logic             rd_upd,
  output logic             wr_upd,
  output logic             clr_cnt,
  output logic [BITS-1:0]  upd_level,
  output logic             sense_en,
  output logic             restore_en,
  output logic             prog_en,
  output logic             drive_neg,
  output logic [BITS-1:0]  drive_level
);
  function automatic logic [BITS-1:0] gray_to_level(input logic [BITS-1:0] g);
    logic [BITS-1:0] b;
    b[BITS-1] = g[BITS-1];
    for (int i = BITS - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CYC_W-1:0] at_least_one(input logic [CYC_W-1:0] v);
    return (v == '0) ? CYC_W'(1) : v;
  endfunction

  phase_e           ph_q;
  logic [CYC_W-1:0] cnt_q, slen_q, plen_q;
  logic             wr_q;
  logic [BITS-1:0]  tgt_q, sensed_q;

  logic accept, sense_done, restore_done, prog_done, refresh_go;

  assign req_ready    = (ph_q == PH_IDLE);
  assign accept       = req_valid && req_ready;
  assign sense_done   = (ph_q == PH_SENSE)   && (cnt_q == slen_q - 1'b1);
  assign restore_done = (ph_q == PH_RESTORE) && (cnt_q == slen_q - 1'b1);
  assign prog_done    = (ph_q == PH_PROGRAM) && (cnt_q == plen_q - 1'b1);
  assign refresh_go   = !refresh_by_count || (cnt_next > read_threshold);

  assign rd_upd    = sense_done && !wr_q;
  assign wr_upd    = sense_done && wr_q;
  assign clr_cnt   = rd_upd && refresh_go;
  assign upd_level = wr_q ? tgt_q : sensed_level;

  assign sense_en    = (ph_q == PH_SENSE);
  assign restore_en  = (ph_q == PH_RESTORE);
  assign prog_en     = (ph_q == PH_PROGRAM);
  assign drive_neg   = restore_en || (prog_en && (tgt_q < sensed_q));
  assign drive_level = prog_en ? tgt_q : (restore_en ? tracked_level : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      slen_q    <= CYC_W'(1);
      plen_q    <= CYC_W'(1);
      wr_q      <= 1'b0;
      tgt_q     <= '0;
      sensed_q  <= '0;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (accept) begin
          ph_q   <= PH_SENSE;
          cnt_q  <= '0;
          slen_q <= at_least_one(sense_cycles);
          plen_q <= at_least_one(prog_cycles);
          wr_q   <= req_write;
          tgt_q  <= gray_to_level(req_wdata);
          addr_q <= req_addr;
        end
        PH_SENSE: if (sense_done) begin
          cnt_q    <= '0;
          sensed_q <= sensed_level;
          if (wr_q) begin
            ph_q <= PH_PROGRAM;
          end else begin
            rsp_valid <= 1'b1;
            rsp_data  <= sensed_gray;
            rsp_err   <= sensed_bad;
            ph_q      <= refresh_go ? PH_RESTORE : PH_IDLE;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_RESTORE: if (restore_done) ph_q <= PH_IDLE;
                    else cnt_q <= cnt_q + 1'b1;
        PH_PROGRAM: if (prog_done) ph_q <= PH_IDLE;
                    else cnt_q <= cnt_q + 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // Checker-side run lengths of the access in flight.
  logic [CYC_W-1:0] chk_sense_run, chk_rest_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_sense_run <= '0;
      chk_rest_run  <= '0;
    end else if (accept) begin
      chk_sense_run <= '0;
      chk_rest_run  <= '0;
    end else begin
      if (sense_en)   chk_sense_run <= chk_sense_run + 1'b1;
      if (restore_en) chk_rest_run  <= chk_rest_run + 1'b1;
    end
  end

  p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sense_en, restore_en, prog_en}));

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_rsp_after_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(sense_en) && !sense_en));

  p_restore_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restore_en) |-> (chk_rest_run == chk_sense_run));

  p_restore_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> drive_neg);
endmodule

// File: rtl/mlc_access_seq.sv
module mlc_access_seq #(
  parameter int BITS  = 2,
  parameter int CELLS = 8,
  parameter int CNT_W = 6,
  parameter int CYC_W = 8,
  localparam int AW   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int NCMP = (1 << BITS) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [BITS-1:0]  req_wdata,
  input  logic [CYC_W-1:0] sense_cycles,
  input  logic [CYC_W-1:0] prog_cycles,
  input  logic             refresh_by_count,
  input  logic [CNT_W-1:0] read_threshold,
  input  logic [NCMP-1:0]  cmp_above,
  output logic             rsp_valid,
  output logic [BITS-1:0]  rsp_data,
  output logic             rsp_err,
  output logic [AW-1:0]    cell_addr,
  output logic             sense_en,
  output logic             restore_en,
  output logic             prog_en,
  output logic             drive_neg,
  output logic [BITS-1:0]  drive_level
);
  logic [BITS-1:0]  dec_level, dec_gray, upd_level, trk_level;
  logic             dec_bad, rd_upd, wr_upd, clr_cnt;
  logic [CNT_W-1:0] cnt_next;

  mlc_level_decode #(.BITS(BITS)) u_dec (
    .cmp      (cmp_above),
    .level    (dec_level),
    .gray     (dec_gray),
    .bad_code (dec_bad)
  );

  mlc_read_tracker #(.BITS(BITS), .CELLS(CELLS), .CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (cell_addr),
    .rd_upd    (rd_upd),
    .wr_upd    (wr_upd),
    .clr_cnt   (clr_cnt),
    .new_level (upd_level),
    .cnt_next  (cnt_next),
    .cur_level (trk_level)
  );

  mlc_phase_seq #(.BITS(BITS), .CELLS(CELLS), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_addr         (req_addr),
    .req_wdata        (req_wdata),
    .sense_cycles     (sense_cycles),
    .prog_cycles      (prog_cycles),
    .refresh_by_count (refresh_by_count),
    .read_threshold   (read_threshold),
    .sensed_level     (dec_level),
    .sensed_gray      (dec_gray),
    .sensed_bad       (dec_bad),
    .cnt_next         (cnt_next),
    .tracked_level    (trk_level),
    .req_ready        (req_ready),
    .rsp_valid        (rsp_valid),
    .rsp_data         (rsp_data),
    .rsp_err          (rsp_err),
    .addr_q           (cell_addr),
    .rd_upd           (rd_upd),
    .wr_upd           (wr_upd),
    .clr_cnt          (clr_cnt),
    .upd_level        (upd_level),
    .sense_en         (sense_en),
    .restore_en       (restore_en),
    .prog_en          (prog_en),
    .drive_neg        (drive_neg),
    .drive_level      (drive_level)
  );
endmodule

// File: tb/tb_mlc_access_seq.sv
module tb_mlc_access_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 0, req_ready, req_write = 0;
  logic [2:0] req_addr = 0;
  logic [1:0] req_wdata = 0;
  logic [7:0] sense_cycles = 8'd2, prog_cycles = 8'd3;
  logic       refresh_by_count = 0;
  logic [5:0] read_threshold = 6'd2;
  logic [2:0] cmp_above = 0;
  logic       rsp_valid, rsp_err, sense_en, restore_en, prog_en, drive_neg;
  logic [1:0] rsp_data, drive_level;
  logic [2:0] cell_addr;

  mlc_access_seq dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [2:0] c);
    return int'(c[0]) + int'(c[1]) + int'(c[2]);
  endfunction

  function automatic int wlevel(input logic [1:0] g);
    case (g)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Results of the last access
  int n_sense, n_rest, n_prog, n_rsp, rest_neg_bad, rest_lvl_bad, ready_bad;
  int prog_neg, prog_lvl;
  logic [1:0] got_d;
  logic got_e;

  task automatic access(input logic wr, input logic [2:0] a, input logic [1:0] wd,
                        input logic [2:0] c, input int rest_lvl);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = wd; cmp_above = c; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n_sense = 0; n_rest = 0; n_prog = 0; n_rsp = 0;
    rest_neg_bad = 0; rest_lvl_bad = 0; ready_bad = 0; prog_neg = -1; prog_lvl = -1;
    for (int g = 0; g < 2000; g++) begin
      if (sense_en) n_sense++;
      if (restore_en) begin
        n_rest++;
        if (!drive_neg) rest_neg_bad++;
        if (int'(drive_level) != rest_lvl) rest_lvl_bad++;
      end
      if (prog_en) begin
        n_prog++; prog_neg = int'(drive_neg); prog_lvl = int'(drive_level);
      end
      if (rsp_valid) begin n_rsp++; got_d = rsp_data; got_e = rsp_err; end
      if (req_ready) break;
      if (!(sense_en || restore_en || prog_en)) ready_bad++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [1:0] wd;
    logic [2:0] cmp;
    logic       pol;
    logic [5:0] thr;
    logic [1:0] exp_d;
    logic       exp_err;
    logic       exp_rest;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 2'b00, 3'b000, 1'b0, 6'd2, 2'b00, 1'b0, 1'b1},
    '{1'b0, 3'd1, 2'b00, 3'b001, 1'b0, 6'd2, 2'b01, 1'b0, 1'b1},
    '{1'b0, 3'd2, 2'b00, 3'b011, 1'b0, 6'd2, 2'b11, 1'b0, 1'b1},
    '{1'b0, 3'd3, 2'b00, 3'b111, 1'b0, 6'd2, 2'b10, 1'b0, 1'b1},
    '{1'b0, 3'd0, 2'b00, 3'b010, 1'b0, 6'd2, 2'b01, 1'b1, 1'b1},
    '{1'b0, 3'd0, 2'b00, 3'b100, 1'b0, 6'd2, 2'b01, 1'b1, 1'b1},
    '{1'b0, 3'd0, 2'b00, 3'b101, 1'b0, 6'd2, 2'b11, 1'b1, 1'b1},
    '{1'b0, 3'd0, 2'b00, 3'b110, 1'b0, 6'd2, 2'b11, 1'b1, 1'b1},
    '{1'b0, 3'd4, 2'b00, 3'b011, 1'b1, 6'd2, 2'b11, 1'b0, 1'b0},
    '{1'b0, 3'd4, 2'b00, 3'b011, 1'b1, 6'd2, 2'b11, 1'b0, 1'b0},
    '{1'b0, 3'd4, 2'b00, 3'b011, 1'b1, 6'd2, 2'b11, 1'b0, 1'b1},
    '{1'b0, 3'd4, 2'b00, 3'b011, 1'b1, 6'd2, 2'b11, 1'b0, 1'b0},
    '{1'b1, 3'd4, 2'b00, 3'b011, 1'b1, 6'd2, 2'b00, 1'b0, 1'b0},
    '{1'b0, 3'd5, 2'b00, 3'b001, 1'b1, 6'd2, 2'b01, 1'b0, 1'b0},
    '{1'b0, 3'd5, 2'b00, 3'b001, 1'b1, 6'd2, 2'b01, 1'b0, 1'b0},
    '{1'b0, 3'd4, 2'b00, 3'b000, 1'b1, 6'd2, 2'b00, 1'b0, 1'b0},
    '{1'b0, 3'd4, 2'b00, 3'b000, 1'b1, 6'd2, 2'b00, 1'b0, 1'b0},
    '{1'b0, 3'd4, 2'b00, 3'b000, 1'b1, 6'd2, 2'b00, 1'b0, 1'b1},
    '{1'b0, 3'd5, 2'b00, 3'b001, 1'b1, 6'd2, 2'b01, 1'b0, 1'b1},
    '{1'b1, 3'd6, 2'b10, 3'b000, 1'b1, 6'd2, 2'b00, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state R1 R10
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R10 enables in reset", int'({sense_en, restore_en, prog_en}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);

    // Vector table: sense 2, program 3
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      refresh_by_count = v.pol; read_threshold = v.thr;
      access(v.wr, v.addr, v.wd, v.cmp, ones(v.cmp));
      chk($sformatf("R2 sense len vec%0d", i), n_sense, 2);
      chk($sformatf("R1 ready low while busy vec%0d", i), ready_bad, 0);
      if (v.wr) begin
        chk($sformatf("R2 prog len vec%0d", i), n_prog, 3);
        chk($sformatf("R2 no rsp on write vec%0d", i), n_rsp, 0);
        chk($sformatf("R9 prog level vec%0d", i), prog_lvl, wlevel(v.wd));
        chk($sformatf("R9 prog polarity vec%0d", i), prog_neg,
            (wlevel(v.wd) < ones(v.cmp)) ? 1 : 0);
      end else begin
        chk($sformatf("R3 rsp count vec%0d", i), n_rsp, 1);
        chk($sformatf("R3 rsp data vec%0d", i), int'(got_d), int'(v.exp_d));
        chk($sformatf("R4 rsp err vec%0d", i), int'(got_e), int'(v.exp_err));
        chk($sformatf("R6 restore len vec%0d", i), n_rest, v.exp_rest ? 2 : 0);
        if (v.exp_rest) begin
          chk($sformatf("R5 restore polarity vec%0d", i), rest_neg_bad, 0);
          chk($sformatf("R5 restore level vec%0d", i), rest_lvl_bad, 0);
        end
      end
    end

    // R2 R5: zero lengths become one cycle, long sense mirrored in restore
    refresh_by_count = 0; sense_cycles = 0; prog_cycles = 0;
    access(0, 3'd7, 2'b00, 3'b001, 1);
    chk("R2 zero sense -> 1", n_sense, 1);
    chk("R5 restore mirrors 1", n_rest, 1);
    access(1, 3'd7, 2'b01, 3'b001, 0);
    chk("R2 zero prog -> 1", n_prog, 1);
    sense_cycles = 5;
    access(0, 3'd7, 2'b00, 3'b111, 3);
    chk("R2 sense len 5", n_sense, 5);
    chk("R5 restore mirrors 5", n_rest, 5);
    chk("R5 restore level 5", rest_lvl_bad, 0);

    // R1: request while busy is dropped
    sense_cycles = 4;
    @(negedge clk);
    req_write = 0; req_addr = 3'd1; cmp_above = 3'b000; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_write = 1; @(negedge clk); @(negedge clk);
    req_valid = 0;
    for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
    begin
      int extra = 0;
      repeat (6) begin @(negedge clk); if (sense_en || prog_en) extra++; end
      chk("R1 busy request ignored", extra, 0);
      chk("R1 ready back", int'(req_ready), 1);
    end

    // R8: saturation of the read counter
    sense_cycles = 1; refresh_by_count = 1; read_threshold = 6'd63;
    begin
      int rests = 0;
      for (int k = 0; k < 65; k++) begin
        access(0, 3'd3, 2'b00, 3'b001, 1);
        rests += n_rest;
      end
      chk("R8 never exceeds max", rests, 0);
    end
    read_threshold = 6'd62;
    access(0, 3'd3, 2'b00, 3'b001, 1);
    chk("R8 saturated count restores", n_rest, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule